// File: doc/BRIEF.md
# Clock-Crossing Serial Peripheral Control Register

This block is the control register of a serial peripheral, such as an SPI engine. It sits on the bus clock, and the serial engine runs on a separate core clock. The register holds three kinds of field.

- **Configuration fields** set the character size, the preload enable, the select-low detect enable, the host select enable and the address mode. They can only be written while the peripheral is disabled. They are held stable while the engine runs, so they reach the core side as plain levels with no synchronizer.
- **The receiver-enable bit** and **the FIFO-flush command** may be written at any time. A flush, or a receiver enable issued while the peripheral runs, crosses into the core domain through a toggle request/acknowledge handshake. Each direction of that handshake uses a chain of synchronizer flops.
- **The busy flag** stays high until the acknowledge comes back. A new flush or deferred enable written while the flag is high is discarded.

On the core side, a flush command becomes a single core-clock pulse for each FIFO it names. The flush field always reads back as zero. The receiver-enable readback tells software where it stands. It reads 1 only once the receiver is truly enabled. Clearing the bit takes effect on the next bus cycle.

Top module: `serial_ctrl_reg`

## Requirements
- R1: After reset the readback is all zeros, every configuration and receiver output is 0, syncBusy is 0 and no flush pulse is driven.
- R2: While periphEnabled is 0, a write updates the configuration fields in the next bus cycle, on both the readback and the cfg outputs. The field positions are:
  - character size in bits [2:0]
  - preload enable in bit 4
  - select-low detect enable in bit 8
  - host select enable in bit 12
  - address mode in bits [17:16]
- R3: While periphEnabled is 1, writes leave every configuration field unchanged.
- R4: The flush command in bits [29:28] is accepted whether or not the peripheral is enabled. A nonzero command written while syncBusy is 0 raises syncBusy in the next bus cycle. A zero command starts no synchronization.
- R5: Writing 1 to the receiver-enable bit (bit 24) while periphEnabled is 0 makes the readback and cfgRxEnable 1 in the next bus cycle.
- R6: Writing 1 to bit 24 while periphEnabled is 1, the bit is 0 and syncBusy is 0 starts a synchronization. The bit keeps reading 0 while syncBusy is high. It becomes 1 in the same bus cycle that syncBusy falls.
- R7: Writing 0 to bit 24 clears the readback and cfgRxEnable in the next bus cycle, even while syncBusy is high. It also cancels a pending deferred enable.
- R8: Each accepted flush command produces exactly one pulse, one core cycle long:
  - command 1 pulses txFlushPulse only
  - command 2 pulses rxFlushPulse only
  - command 3 pulses both in the same core cycle

  Bits [29:28] always read back as 0.
- R9: syncBusy falls only after the core side has acknowledged. While syncBusy is high, a flush command and a deferred receiver enable are both dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| busRstN | input | 1 | Active-low asynchronous reset, bus side |
| coreClk | input | 1 | Peripheral core clock |
| coreRstN | input | 1 | Active-low asynchronous reset, core side |
| wrEn | input | 1 | Register write strobe, one bus cycle per write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Register readback |
| periphEnabled | input | 1 | Peripheral enable state, bus domain |
| syncBusy | output | 1 | A synchronized write is still crossing |
| cfgCharSize | output | 3 | Character size setting |
| cfgPreloadEn | output | 1 | Preload enable |
| cfgLowDetEn | output | 1 | Select-low detect enable |
| cfgHostSelEn | output | 1 | Hardware host select enable |
| cfgAddrMode | output | 2 | Address matching mode |
| cfgRxEnable | output | 1 | Receiver enable |
| txFlushPulse | output | 1 | One-core-cycle transmit FIFO clear |
| rxFlushPulse | output | 1 | One-core-cycle receive FIFO clear |

## Verification
The assertions take two things for granted:
- wrEn is a single-cycle strobe sampled on the bus clock.
- periphEnabled changes only between writes, never in the same cycle as a write it is meant to govern.

The core-side pulse checks also rely on the handshake round trip being longer than one core cycle, which any synchronizer depth of two or more gives. The stimulus follows these assumptions:
- It drives writes and the enable level at the bus-clock falling edge, one write per cycle.
- It flips periphEnabled only while no write is in flight.
- It waits for syncBusy to fall, with a bound, before any write whose acceptance it expects.

// File: rtl/serial_ctrl_pkg.sv
package serial_ctrl_pkg;
  localparam int REG_W       = 32;
  localparam int CHSZ_LSB    = 0;
  localparam int CHSZ_W      = 3;
  localparam int PRELOAD_BIT = 4;
  localparam int LOWDET_BIT  = 8;
  localparam int HOSTSEL_BIT = 12;
  localparam int AMODE_LSB   = 16;
  localparam int AMODE_W     = 2;
  localparam int RXEN_BIT    = 24;
  localparam int FLUSH_LSB   = 28;
  localparam int FLUSH_W     = 2;

  // strobes from bus-side control to the register datapath
  typedef struct packed {
    logic loadCfg;   // protected fields take write data
    logic rxSetNow;  // receiver enable set immediately
    logic rxClear;   // receiver enable cleared immediately
    logic launch;    // capture flush command, start handshake
    logic rxCommit;  // deferred receiver enable completes
  } ctlStrobe_t;
endpackage

// File: rtl/serial_ctrl_sync.sv
module serial_ctrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_ctrl_ctl.sv
module serial_ctrl_ctl
  import serial_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               busClk,
  input  logic               busRstN,
  input  logic               wrEn,
  input  logic               wrRxBit,
  input  logic [FLUSH_W-1:0] wrFlush,
  input  logic               periphEnabled,
  input  logic               rxEnCur,
  input  logic               ackTgl,
  output ctlStrobe_t         strobe,
  output logic               reqTgl,
  output logic               syncBusy
);
  logic ackSyncd, ackPrev, busyQ, reqQ, pendRx;
  logic ackEdge, needRx, flushReq;

  serial_ctrl_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(busClk), .rstN(busRstN), .d(ackTgl), .q(ackSyncd)
  );

  assign ackEdge = ackSyncd ^ ackPrev;

  always_comb begin
    needRx          = wrEn & wrRxBit & periphEnabled & ~rxEnCur & ~busyQ;
    flushReq        = wrEn & (wrFlush != '0) & ~busyQ;
    strobe.loadCfg  = wrEn & ~periphEnabled;
    strobe.rxSetNow = wrEn & wrRxBit & ~periphEnabled;
    strobe.rxClear  = wrEn & ~wrRxBit;
    strobe.launch   = needRx | flushReq;
    strobe.rxCommit = ackEdge & pendRx;
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      ackPrev <= 1'b0;
      busyQ   <= 1'b0;
      reqQ    <= 1'b0;
      pendRx  <= 1'b0;
    end else begin
      ackPrev <= ackSyncd;
      if (strobe.launch) begin
        reqQ  <= ~reqQ;
        busyQ <= 1'b1;
      end else if (ackEdge) begin
        busyQ <= 1'b0;
      end
      if (strobe.rxClear)  pendRx <= 1'b0;
      else if (needRx)     pendRx <= 1'b1;
      else if (ackEdge)    pendRx <= 1'b0;
    end
  end

  assign reqTgl   = reqQ;
  assign syncBusy = busyQ;
endmodule

// File: rtl/serial_ctrl_dp.sv
module serial_ctrl_dp
  import serial_ctrl_pkg::*;
(
  input  logic               busClk,
  input  logic               busRstN,
  input  logic [REG_W-1:0]   wrData,
  input  ctlStrobe_t         strobe,
  output logic [CHSZ_W-1:0]  charSize,
  output logic               preloadEn,
  output logic               lowDetEn,
  output logic               hostSelEn,
  output logic [AMODE_W-1:0] addrMode,
  output logic               rxEnable,
  output logic [FLUSH_W-1:0] flushCode,
  output logic [REG_W-1:0]   rdData
);
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      charSize  <= '0;
      preloadEn <= 1'b0;
      lowDetEn  <= 1'b0;
      hostSelEn <= 1'b0;
      addrMode  <= '0;
      rxEnable  <= 1'b0;
      flushCode <= '0;
    end else begin
      if (strobe.loadCfg) begin
        charSize  <= wrData[CHSZ_LSB +: CHSZ_W];
        preloadEn <= wrData[PRELOAD_BIT];
        lowDetEn  <= wrData[LOWDET_BIT];
        hostSelEn <= wrData[HOSTSEL_BIT];
        addrMode  <= wrData[AMODE_LSB +: AMODE_W];
      end
      if (strobe.rxClear)                         rxEnable <= 1'b0;
      else if (strobe.rxSetNow || strobe.rxCommit) rxEnable <= 1'b1;
      if (strobe.launch) flushCode <= wrData[FLUSH_LSB +: FLUSH_W];
    end
  end

  always_comb begin
    rdData = '0;
    rdData[CHSZ_LSB +: CHSZ_W]   = charSize;
    rdData[PRELOAD_BIT]          = preloadEn;
    rdData[LOWDET_BIT]           = lowDetEn;
    rdData[HOSTSEL_BIT]          = hostSelEn;
    rdData[AMODE_LSB +: AMODE_W] = addrMode;
    rdData[RXEN_BIT]             = rxEnable;
  end
endmodule

// File: rtl/serial_ctrl_core.sv
module serial_ctrl_core
  import serial_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               coreClk,
  input  logic               coreRstN,
  input  logic               reqTgl,
  input  logic [FLUSH_W-1:0] flushCode,
  output logic               ackTgl,
  output logic               txPulse,
  output logic               rxPulse
);
  logic reqSyncd, reqPrev, reqEdge;

  serial_ctrl_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(coreClk), .rstN(coreRstN), .d(reqTgl), .q(reqSyncd)
  );

  assign reqEdge = reqSyncd ^ reqPrev;

  // flushCode is held by the bus side until the acknowledge returns
  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      reqPrev <= 1'b0;
      ackTgl  <= 1'b0;
      txPulse <= 1'b0;
      rxPulse <= 1'b0;
    end else begin
      reqPrev <= reqSyncd;
      txPulse <= reqEdge & flushCode[0];
      rxPulse <= reqEdge & flushCode[1];
      if (reqEdge) ackTgl <= ~ackTgl;
    end
  end
endmodule

// File: rtl/serial_ctrl_reg.sv
module serial_ctrl_reg
  import serial_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               busClk,
  input  logic               busRstN,
  input  logic               coreClk,
  input  logic               coreRstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  input  logic               periphEnabled,
  output logic               syncBusy,
  output logic [CHSZ_W-1:0]  cfgCharSize,
  output logic               cfgPreloadEn,
  output logic               cfgLowDetEn,
  output logic               cfgHostSelEn,
  output logic [AMODE_W-1:0] cfgAddrMode,
  output logic               cfgRxEnable,
  output logic               txFlushPulse,
  output logic               rxFlushPulse
);
  ctlStrobe_t         strobe;
  logic               reqTgl, ackTgl;
  logic [FLUSH_W-1:0] flushCode;

  serial_ctrl_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn),
    .wrRxBit(wrData[RXEN_BIT]), .wrFlush(wrData[FLUSH_LSB +: FLUSH_W]),
    .periphEnabled(periphEnabled), .rxEnCur(cfgRxEnable), .ackTgl(ackTgl),
    .strobe(strobe), .reqTgl(reqTgl), .syncBusy(syncBusy)
  );

  serial_ctrl_dp u_dp (
    .busClk(busClk), .busRstN(busRstN), .wrData(wrData), .strobe(strobe),
    .charSize(cfgCharSize), .preloadEn(cfgPreloadEn), .lowDetEn(cfgLowDetEn),
    .hostSelEn(cfgHostSelEn), .addrMode(cfgAddrMode), .rxEnable(cfgRxEnable),
    .flushCode(flushCode), .rdData(rdData)
  );

  serial_ctrl_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
    .coreClk(coreClk), .coreRstN(coreRstN), .reqTgl(reqTgl),
    .flushCode(flushCode), .ackTgl(ackTgl),
    .txPulse(txFlushPulse), .rxPulse(rxFlushPulse)
  );
endmodule

// File: rtl/serial_ctrl_chk.sv
module serial_ctrl_chk
  import serial_ctrl_pkg::*;
(
  input logic               busClk,
  input logic               busRstN,
  input logic               coreClk,
  input logic               coreRstN,
  input logic               wrEn,
  input logic [REG_W-1:0]   wrData,
  input logic [REG_W-1:0]   rdData,
  input logic               periphEnabled,
  input logic               syncBusy,
  input logic [CHSZ_W-1:0]  cfgCharSize,
  input logic [AMODE_W-1:0] cfgAddrMode,
  input logic               cfgRxEnable,
  input logic               txFlushPulse,
  input logic               rxFlushPulse
);
  assert_cfg_frozen_R3: assert property (@(posedge busClk) disable iff (!busRstN)
    periphEnabled |=> ($stable(cfgCharSize) && $stable(cfgAddrMode)));

  assert_flush_starts_sync_R4: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrEn && !syncBusy && wrData[FLUSH_LSB +: FLUSH_W] != '0) |=> syncBusy);

  assert_busy_needs_write_R9: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(syncBusy) |-> $past(wrEn));

  assert_rx_set_now_R5: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrEn && !periphEnabled && wrData[RXEN_BIT]) |=> cfgRxEnable);

  assert_rx_deferred_R6: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrEn && periphEnabled && wrData[RXEN_BIT] && !rdData[RXEN_BIT]) |=> !rdData[RXEN_BIT]);

  assert_rx_clear_R7: assert property (@(posedge busClk) disable iff (!busRstN)
    (wrEn && !wrData[RXEN_BIT]) |=> !cfgRxEnable);

  assert_tx_pulse_single_R8: assert property (@(posedge coreClk) disable iff (!coreRstN)
    txFlushPulse |=> !txFlushPulse);

  assert_rx_pulse_single_R8: assert property (@(posedge coreClk) disable iff (!coreRstN)
    rxFlushPulse |=> !rxFlushPulse);
endmodule

bind serial_ctrl_reg serial_ctrl_chk u_chk (
  .busClk(busClk), .busRstN(busRstN), .coreClk(coreClk), .coreRstN(coreRstN),
  .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .periphEnabled(periphEnabled),
  .syncBusy(syncBusy), .cfgCharSize(cfgCharSize), .cfgAddrMode(cfgAddrMode),
  .cfgRxEnable(cfgRxEnable), .txFlushPulse(txFlushPulse), .rxFlushPulse(rxFlushPulse)
);

// File: tb/serial_ctrl_reg_tb.sv
module serial_ctrl_reg_tb;
  logic        busClk = 1'b0, coreClk = 1'b0;
  logic        busRstN = 1'b0, coreRstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        periphEnabled = 1'b0;
  logic        syncBusy;
  logic [2:0]  cfgCharSize;
  logic        cfgPreloadEn, cfgLowDetEn, cfgHostSelEn, cfgRxEnable;
  logic [1:0]  cfgAddrMode;
  logic        txFlushPulse, rxFlushPulse;

  int checks = 0, errors = 0;
  bit done = 0;
  bit monOn = 0;
  logic [1:0] expQ[$];

  always #4 busClk = ~busClk;    // 125 MHz
  always #5.5 coreClk = ~coreClk;

  serial_ctrl_reg u_dut (
    .busClk(busClk), .busRstN(busRstN), .coreClk(coreClk), .coreRstN(coreRstN),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .periphEnabled(periphEnabled),
    .syncBusy(syncBusy), .cfgCharSize(cfgCharSize), .cfgPreloadEn(cfgPreloadEn),
    .cfgLowDetEn(cfgLowDetEn), .cfgHostSelEn(cfgHostSelEn), .cfgAddrMode(cfgAddrMode),
    .cfgRxEnable(cfgRxEnable), .txFlushPulse(txFlushPulse), .rxFlushPulse(rxFlushPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgOut();
    cfgOut = {7'd0, cfgRxEnable, 6'd0, cfgAddrMode, 3'd0, cfgHostSelEn, 3'd0,
              cfgLowDetEn, 3'd0, cfgPreloadEn, 1'b0, cfgCharSize};
  endfunction

  // one write; returns at the following falling edge, after the update
  task automatic busWrite(input logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge busClk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  // driver side of the scoreboard: push expected flush, then write
  task automatic flushWrite(input logic [31:0] d);
    if (d[29:28] != 2'b00) expQ.push_back(d[29:28]);
    busWrite(d);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (syncBusy && n < 200) begin
      @(negedge busClk);
      n++;
    end
    if (syncBusy) chk("R9 busy never cleared", 32'(syncBusy), 32'd0);
  endtask

  // monitor side of the scoreboard
  always @(negedge coreClk) begin
    if (monOn && (txFlushPulse || rxFlushPulse)) begin
      if (expQ.size() == 0) begin
        chk("R8 unexpected flush pulse", {30'd0, rxFlushPulse, txFlushPulse}, 32'd0);
      end else begin
        logic [1:0] e;
        e = expQ.pop_front();
        chk("R8 flush pulse targets", {30'd0, rxFlushPulse, txFlushPulse}, {30'd0, e});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge busClk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge busClk);
    busRstN = 1'b1;
    coreRstN = 1'b1;
    @(negedge busClk);
    monOn = 1;

    chk("R1 reset readback", rdData, 32'd0);
    chk("R1 reset outputs", cfgOut(), 32'd0);
    chk("R1 reset busy/pulses", {29'd0, syncBusy, txFlushPulse, rxFlushPulse}, 32'd0);

    // R2: configuration written while disabled
    busWrite(32'h0002_0115);
    chk("R2 cfg readback", rdData, 32'h0002_0115);
    chk("R2 cfg outputs", cfgOut(), 32'h0002_0115);

    // R3: configuration ignored while enabled
    periphEnabled = 1'b1;
    @(negedge busClk);
    busWrite(32'h0001_1007);
    chk("R3 cfg readback unchanged", rdData, 32'h0002_0115);
    chk("R3 cfg outputs unchanged", cfgOut(), 32'h0002_0115);
    periphEnabled = 1'b0;
    @(negedge busClk);

    // R5: immediate receiver enable while disabled
    busWrite(32'h0102_0115);
    chk("R5 rx set at once", rdData, 32'h0102_0115);
    chk("R5 rx output", 32'(cfgRxEnable), 32'd1);
    chk("R5 no sync for immediate set", 32'(syncBusy), 32'd0);

    // R7: clear
    busWrite(32'h0002_0115);
    chk("R7 rx cleared", rdData, 32'h0002_0115);

    // R6: deferred enable while enabled
    periphEnabled = 1'b1;
    @(negedge busClk);
    busWrite(32'h0100_0000);
    chk("R6 rx reads 0 while syncing", rdData, 32'h0002_0115);
    chk("R6 busy raised", 32'(syncBusy), 32'd1);
    while (syncBusy) begin
      chk("R6 rx stays 0 while busy", 32'(rdData[24]), 32'd0);
      @(negedge busClk);
    end
    chk("R6 rx reads 1 when busy falls", rdData, 32'h0102_0115);
    chk("R6 rx output active", 32'(cfgRxEnable), 32'd1);

    // R4/R8: flush commands accepted while enabled
    flushWrite(32'h1100_0000);
    chk("R4 flush raises busy", 32'(syncBusy), 32'd1);
    chk("R8 flush reads back 0", 32'(rdData[29:28]), 32'd0);
    waitIdle();
    flushWrite(32'h2100_0000);
    waitIdle();
    flushWrite(32'h3100_0000);
    chk("R8 both flush reads back 0", rdData, 32'h0102_0115);
    waitIdle();
    flushWrite(32'h0100_0000);
    chk("R4 zero command starts no sync", 32'(syncBusy), 32'd0);

    // R9: flush while busy is dropped
    flushWrite(32'h1100_0000);
    busWrite(32'h2100_0000);
    waitIdle();
    chk("R9 busy cleared after ack", 32'(syncBusy), 32'd0);

    // R9: deferred enable while busy is dropped
    busWrite(32'h0000_0000);
    flushWrite(32'h1000_0000);
    busWrite(32'h0100_0000);
    waitIdle();
    chk("R9 rx set dropped while busy", 32'(rdData[24]), 32'd0);

    // R7: clear cancels pending deferred enable
    busWrite(32'h0100_0000);
    busWrite(32'h0000_0000);
    chk("R7 clear during sync", 32'(cfgRxEnable), 32'd0);
    waitIdle();
    @(negedge busClk);
    chk("R7 pending enable cancelled", 32'(rdData[24]), 32'd0);

    repeat (20) @(negedge coreClk);
    chk("R8 every flush pulsed once", expQ.size(), 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule